// File: doc/BRIEF.md
# Lane Alignment Character Monitor

This block sits on one receive lane during the user-data phase of a multi-lane converter link. Each cycle it takes one already-decoded octet and a flag that marks the octet as a control character. It keeps its own count of where each frame and each multiframe ends. A frame is `F` octets and a multiframe is `K` frames.

The transmitter may send a frame-end or multiframe-end octet as an alignment character when that octet repeats the value sent at the same position one frame, or one multiframe, earlier. The monitor puts the stored data value back in place of each alignment character. It flags any alignment character that lands off the expected boundary. When the same misplaced position is seen twice in a row, it moves its own boundary counters to that position.

Counting starts from a single-cycle start pulse that marks the first user-data octet. Every output is registered and appears one cycle after the input octet.

Top module: `lane_align_monitor`

## Requirements
- R1: Before the first start pulse after reset, `out_valid`, `out_eof`, `out_eomf`, `out_ferr` and `out_mferr` stay low, and the input octet and flag pass to the outputs unchanged. From the start-pulse octet onwards, `out_valid` is high. Every output follows its input octet by exactly one cycle.
- R2: The octet that comes with the start pulse is octet 0 of frame 0. `out_eof` marks octet `F-1` of each frame. `out_eomf` marks the last octet of frame `K-1`, and it is always accompanied by `out_eof`.
- R3: An input with the control flag set and value 0xFC is a frame alignment character. It is output as the last octet, already restored, that was seen at a frame end, and its output control flag is cleared.
- R4: An input with the control flag set and value 0x7C is a multiframe alignment character. It is output as the last octet, already restored, that was seen at a multiframe end, and its output control flag is cleared.
- R5: Each start pulse clears both stored end-of-frame and end-of-multiframe values to zero.
- R6: A frame alignment character that arrives on an octet other than the local frame end raises `out_ferr` for exactly that output octet.
- R7: A multiframe alignment character that arrives on an octet other than the local multiframe end raises `out_mferr` for exactly that output octet.
- R8: A single misplaced alignment character does not change the positions of the local frame or multiframe boundaries.
- R9: If the same misplaced position is seen for a second consecutive time, the counters are moved. For a frame character, the position within the frame must match; the next octet then starts a new frame and the frame index advances. For a multiframe character, the position within the multiframe must match; the next octet then starts frame 0. The markers on the octet that triggers the move still come from the old counting.
- R10: A correctly placed alignment character of a given kind cancels any pending misplaced position for that kind. A misplaced one at a different position replaces the pending position.
- R11: A start pulse while counting is already under way restarts counting and clears any pending misplaced positions.
- R12: Control octets other than the two alignment values, and all data octets, pass through unchanged with their flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sod | input | 1 | Pulse marking the first user-data octet |
| rx_octet | input | W | Decoded input octet |
| rx_ctrl | input | 1 | Input octet is a control character |
| out_valid | output | 1 | Counting is active for this output octet |
| out_octet | output | W | Restored octet |
| out_ctrl | output | 1 | Control flag after restoration |
| out_eof | output | 1 | Output octet is the local frame end |
| out_eomf | output | 1 | Output octet is the local multiframe end |
| out_ferr | output | 1 | Misplaced frame alignment character |
| out_mferr | output | 1 | Misplaced multiframe alignment character |

## Verification
A multiframe character that arrives on a local frame end that is not the multiframe end does three things in one cycle. It is restored from the multiframe history. The restored value is written into the frame-end history. An error is raised, and it may also be the octet that moves the counters. The same kind of collision happens when a second misplaced character re-phases the counters in the same cycle as its own restoration and error pulse. Both cases are produced directly, and also many times over in a long random phase that mixes repeated positions with start pulses. Each time, a behavioural model built on a single multiframe position index judges the result on every clock.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam logic [7:0] CODE_FRAME_ALIGN = 8'hFC;
  localparam logic [7:0] CODE_MF_ALIGN    = 8'h7C;
endpackage

// File: rtl/lane_pos_track.sv
module lane_pos_track #(
  parameter int F = 2,
  parameter int K = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sod,
  input  logic is_f,
  input  logic is_a,
  output logic cur_active,
  output logic at_eof,
  output logic at_eomf,
  output logic ferr_c,
  output logic mferr_c
);
  localparam int FW = (F > 1) ? $clog2(F) : 1;
  localparam int KW = (K > 1) ? $clog2(K) : 1;

  logic          act_q;
  logic [FW-1:0] fpos_q, fpos_d, cur_f;
  logic [KW-1:0] fidx_q, fidx_d, cur_k;
  logic          cf_v_q, cf_v, cf_v_d;
  logic [FW-1:0] cf_pos_q, cf_pos_d;
  logic          ca_v_q, ca_v, ca_v_d;
  logic [FW-1:0] ca_f_q, ca_f_d;
  logic [KW-1:0] ca_k_q, ca_k_d;
  logic          rephase_f, rephase_a;

  always_comb begin
    cur_active = sod | act_q;
    cur_f      = sod ? '0 : fpos_q;
    cur_k      = sod ? '0 : fidx_q;
    cf_v       = sod ? 1'b0 : cf_v_q;
    ca_v       = sod ? 1'b0 : ca_v_q;
    at_eof     = cur_active && (cur_f == FW'(F-1));
    at_eomf    = at_eof && (cur_k == KW'(K-1));
    ferr_c     = cur_active && is_f && !at_eof;
    mferr_c    = cur_active && is_a && !at_eomf;
    rephase_f  = ferr_c && cf_v && (cf_pos_q == cur_f);
    rephase_a  = mferr_c && ca_v && (ca_f_q == cur_f) && (ca_k_q == cur_k);

    fpos_d = fpos_q;
    fidx_d = fidx_q;
    if (cur_active) begin
      if (rephase_a) begin
        fpos_d = '0;
        fidx_d = '0;
      end else if (rephase_f || at_eof) begin
        fpos_d = '0;
        fidx_d = (cur_k == KW'(K-1)) ? '0 : cur_k + KW'(1);
      end else begin
        fpos_d = cur_f + FW'(1);
        fidx_d = cur_k;
      end
    end

    cf_v_d   = cf_v;
    cf_pos_d = cf_pos_q;
    if (cur_active && is_f) begin
      if (ferr_c && !rephase_f) begin
        cf_v_d   = 1'b1;
        cf_pos_d = cur_f;
      end else begin
        cf_v_d   = 1'b0;
      end
    end

    ca_v_d = ca_v;
    ca_f_d = ca_f_q;
    ca_k_d = ca_k_q;
    if (cur_active && is_a) begin
      if (mferr_c && !rephase_a) begin
        ca_v_d = 1'b1;
        ca_f_d = cur_f;
        ca_k_d = cur_k;
      end else begin
        ca_v_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      fpos_q   <= '0;
      fidx_q   <= '0;
      cf_v_q   <= 1'b0;
      cf_pos_q <= '0;
      ca_v_q   <= 1'b0;
      ca_f_q   <= '0;
      ca_k_q   <= '0;
    end else begin
      act_q    <= cur_active;
      fpos_q   <= fpos_d;
      fidx_q   <= fidx_d;
      cf_v_q   <= cf_v_d;
      cf_pos_q <= cf_pos_d;
      ca_v_q   <= ca_v_d;
      ca_f_q   <= ca_f_d;
      ca_k_q   <= ca_k_d;
    end
  end
endmodule

// File: rtl/lane_restore.sv
module lane_restore #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cur_active,
  input  logic [W-1:0] oct_in,
  input  logic         ctrl_in,
  input  logic         is_f,
  input  logic         is_a,
  input  logic         at_eof,
  input  logic         at_eomf,
  output logic [W-1:0] oct_rst,
  output logic         ctrl_rst
);
  logic [W-1:0] eof_h, eomf_h, eof_v, eomf_v;

  always_comb begin
    eof_v    = clr ? '0 : eof_h;
    eomf_v   = clr ? '0 : eomf_h;
    oct_rst  = oct_in;
    ctrl_rst = ctrl_in;
    if (cur_active && is_a) begin
      oct_rst  = eomf_v;
      ctrl_rst = 1'b0;
    end else if (cur_active && is_f) begin
      oct_rst  = eof_v;
      ctrl_rst = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eof_h  <= '0;
      eomf_h <= '0;
    end else begin
      eof_h  <= (cur_active && at_eof)  ? oct_rst : eof_v;
      eomf_h <= (cur_active && at_eomf) ? oct_rst : eomf_v;
    end
  end
endmodule

// File: rtl/lane_align_monitor.sv
module lane_align_monitor
  import lane_align_pkg::*;
#(
  parameter int W = 8,
  parameter int F = 2,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sod,
  input  logic [W-1:0] rx_octet,
  input  logic         rx_ctrl,
  output logic         out_valid,
  output logic [W-1:0] out_octet,
  output logic         out_ctrl,
  output logic         out_eof,
  output logic         out_eomf,
  output logic         out_ferr,
  output logic         out_mferr
);
  logic         is_f, is_a;
  logic         cur_active, at_eof, at_eomf, ferr_c, mferr_c;
  logic [W-1:0] oct_rst;
  logic         ctrl_rst;

  assign is_f = rx_ctrl && (rx_octet == W'(CODE_FRAME_ALIGN));
  assign is_a = rx_ctrl && (rx_octet == W'(CODE_MF_ALIGN));

  lane_pos_track #(.F(F), .K(K)) u_track (
    .clk(clk), .rst(rst), .sod(sod), .is_f(is_f), .is_a(is_a),
    .cur_active(cur_active), .at_eof(at_eof), .at_eomf(at_eomf),
    .ferr_c(ferr_c), .mferr_c(mferr_c)
  );

  lane_restore #(.W(W)) u_restore (
    .clk(clk), .rst(rst), .clr(sod), .cur_active(cur_active),
    .oct_in(rx_octet), .ctrl_in(rx_ctrl), .is_f(is_f), .is_a(is_a),
    .at_eof(at_eof), .at_eomf(at_eomf),
    .oct_rst(oct_rst), .ctrl_rst(ctrl_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_octet <= '0;
      out_ctrl  <= 1'b0;
      out_eof   <= 1'b0;
      out_eomf  <= 1'b0;
      out_ferr  <= 1'b0;
      out_mferr <= 1'b0;
    end else begin
      out_valid <= cur_active;
      out_octet <= oct_rst;
      out_ctrl  <= ctrl_rst;
      out_eof   <= at_eof;
      out_eomf  <= at_eomf;
      out_ferr  <= ferr_c;
      out_mferr <= mferr_c;
    end
  end
endmodule

// File: rtl/lane_align_monitor_chk.sv
module lane_align_monitor_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sod,
  input logic         out_valid,
  input logic [W-1:0] out_octet,
  input logic         out_ctrl,
  input logic         out_eof,
  input logic         out_eomf,
  input logic         out_ferr,
  input logic         out_mferr
);
  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(sod) || $past(out_valid))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(out_eof || out_eomf || out_ferr || out_mferr)); // R1
  AST_EOMF_WITH_EOF: assert property (@(posedge clk) disable iff (rst)
    out_eomf |-> out_eof); // R2
  AST_NO_ALIGN_LEAK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_ctrl && (out_octet == W'(8'hFC) || out_octet == W'(8'h7C)))); // R3
  AST_FERR_OFF_END: assert property (@(posedge clk) disable iff (rst)
    out_ferr |-> (out_valid && !out_eof)); // R6
  AST_MFERR_OFF_END: assert property (@(posedge clk) disable iff (rst)
    out_mferr |-> (out_valid && !out_eomf)); // R7
  AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_ferr, out_mferr})); // R6
endmodule

bind lane_align_monitor lane_align_monitor_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sod(sod), .out_valid(out_valid),
  .out_octet(out_octet), .out_ctrl(out_ctrl), .out_eof(out_eof),
  .out_eomf(out_eomf), .out_ferr(out_ferr), .out_mferr(out_mferr)
);

// File: tb/tb_lane_align_monitor.sv
module tb_lane_align_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int F  = 2;
  localparam int K  = 4;
  localparam int MF = F * K;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sod = 1'b0;
  logic [7:0] rx_octet = 8'h00;
  logic       rx_ctrl = 1'b0;
  logic       out_valid, out_ctrl, out_eof, out_eomf, out_ferr, out_mferr;
  logic [7:0] out_octet;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_align_monitor #(.W(8), .F(F), .K(K)) dut (
    .clk(clk), .rst(rst), .sod(sod), .rx_octet(rx_octet), .rx_ctrl(rx_ctrl),
    .out_valid(out_valid), .out_octet(out_octet), .out_ctrl(out_ctrl),
    .out_eof(out_eof), .out_eomf(out_eomf), .out_ferr(out_ferr),
    .out_mferr(out_mferr)
  );

  // Reference model: one position index across the multiframe
  int         m_act, m_pos, m_cfv, m_cfp, m_cav, m_cap;
  logic [7:0] m_eofh, m_eomfh;
  logic       e_valid, e_ctrl, e_eof, e_eomf, e_ferr, e_mferr;
  logic [7:0] e_oct;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_pos = 0; m_cfv = 0; m_cfp = 0; m_cav = 0; m_cap = 0;
      m_eofh = 0; m_eomfh = 0;
      e_valid = 0; e_oct = 0; e_ctrl = 0; e_eof = 0; e_eomf = 0;
      e_ferr = 0; e_mferr = 0;
    end else begin
      if (sod) begin
        m_act = 1; m_pos = 0; m_eofh = 0; m_eomfh = 0; m_cfv = 0; m_cav = 0;
      end
      if (m_act == 0) begin
        e_valid = 0; e_oct = rx_octet; e_ctrl = rx_ctrl;
        e_eof = 0; e_eomf = 0; e_ferr = 0; e_mferr = 0;
      end else begin
        int fp, nextpos;
        logic isf, isa, eof, eomf, fe, me, c;
        logic [7:0] o;
        fp   = m_pos % F;
        eof  = (fp == F - 1);
        eomf = (m_pos == MF - 1);
        isf  = rx_ctrl && rx_octet == 8'hFC;
        isa  = rx_ctrl && rx_octet == 8'h7C;
        o = rx_octet; c = rx_ctrl;
        if (isa) begin o = m_eomfh; c = 0; end
        else if (isf) begin o = m_eofh; c = 0; end
        fe = isf && !eof;
        me = isa && !eomf;
        nextpos = (m_pos + 1) % MF;
        if (isf) begin
          if (fe && m_cfv != 0 && m_cfp == fp) begin
            nextpos = ((m_pos / F + 1) * F) % MF; m_cfv = 0;
          end else if (fe) begin m_cfv = 1; m_cfp = fp; end
          else m_cfv = 0;
        end
        if (isa) begin
          if (me && m_cav != 0 && m_cap == m_pos) begin
            nextpos = 0; m_cav = 0;
          end else if (me) begin m_cav = 1; m_cap = m_pos; end
          else m_cav = 0;
        end
        if (eof)  m_eofh  = o;
        if (eomf) m_eomfh = o;
        m_pos = nextpos;
        e_valid = 1; e_oct = o; e_ctrl = c; e_eof = eof; e_eomf = eomf;
        e_ferr = fe; e_mferr = me;
      end
    end
  end

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "valid(R1)",  out_valid, e_valid);
    chk(tag, "octet(R3,R4,R12)", out_octet, e_oct);
    chk(tag, "ctrl(R3,R12)", out_ctrl, e_ctrl);
    chk(tag, "eof(R2)",    out_eof, e_eof);
    chk(tag, "eomf(R2)",   out_eomf, e_eomf);
    chk(tag, "ferr(R6)",   out_ferr, e_ferr);
    chk(tag, "mferr(R7)",  out_mferr, e_mferr);
  endtask

  task automatic step(input logic [7:0] o, input logic c, input logic s, input string tag);
    rx_octet = o; rx_ctrl = c; sod = s;
    @(negedge clk);
    check_all(tag);
  endtask

  // Transmit-side insertion for realistic streams
  int tx_pos;
  logic [7:0] tx_eof, tx_eomf;
  task automatic tx_send(input logic [7:0] d, input logic s, input string tag);
    logic [7:0] o; logic c;
    if (s) begin tx_pos = 0; tx_eof = 0; tx_eomf = 0; end
    o = d; c = 0;
    if (tx_pos == MF - 1 && d == tx_eomf) begin o = 8'h7C; c = 1; end
    else if (tx_pos % F == F - 1 && d == tx_eof) begin o = 8'hFC; c = 1; end
    if (tx_pos % F == F - 1) tx_eof = d;
    if (tx_pos == MF - 1) tx_eomf = d;
    tx_pos = (tx_pos + 1) % MF;
    step(o, c, s, tag);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst = 1;
    @(negedge clk);
    step(8'h11, 0, 0, "R1 reset");
    step(8'h22, 1, 0, "R1 reset");
    rst = 0;
    step(8'h55, 0, 0, "R1 idle pass");
    step(8'hFC, 1, 0, "R1 idle pass");
    step(8'h7C, 1, 0, "R1 idle pass");

    // R2 R3 R4 R5: start and restoration through transmit insertion
    for (int i = 0; i < 48; i++)
      tx_send(8'((i / 5) & 8'h03), i == 0, "R2 R3 R4 R5 insertion");
    // R8: single misplaced frame char (start of a frame)
    step(8'h01, 0, 1, "R11 restart");
    step(8'h02, 0, 0, "R2");
    step(8'hFC, 1, 0, "R6 R8 single misplaced");
    for (int i = 0; i < 9; i++) step(8'(i + 3), 0, 0, "R8 no move");
    // R9: twice at the same frame position
    step(8'hA0, 0, 1, "R11 restart");
    step(8'hA1, 0, 0, "R2");
    step(8'hFC, 1, 0, "R6 first misplaced");
    step(8'hA3, 0, 0, "R9");
    step(8'hFC, 1, 0, "R9 second misplaced frame");
    for (int i = 0; i < 10; i++) step(8'(8'hB0 + i), 0, 0, "R9 rephased frame");
    // R10: correct char in between cancels
    step(8'hC0, 0, 1, "R11 restart");
    step(8'hC1, 0, 0, "R2");
    step(8'hFC, 1, 0, "R6 misplaced");
    step(8'hFC, 1, 0, "R10 correct cancels");
    step(8'hFC, 1, 0, "R10 misplaced again no move");
    for (int i = 0; i < 6; i++) step(8'(8'hC8 + i), 0, 0, "R10 no move");
    // R7 R9: multiframe char twice at the same position, on a frame end
    step(8'hD0, 0, 1, "R11 restart");
    for (int i = 1; i < MF; i++) step(8'(8'hD0 + i), 0, 0, "R2");
    step(8'hE0, 0, 0, "R2");
    step(8'h7C, 1, 0, "R7 R4 misplaced on frame end");
    for (int i = 2; i < MF; i++) step(8'(8'hE0 + i), 0, 0, "R2");
    step(8'hE8, 0, 0, "R2");
    step(8'h7C, 1, 0, "R9 second misplaced multiframe");
    for (int i = 0; i < 2 * MF; i++) step(8'(8'hF0 + i), 0, 0, "R9 rephased multiframe");
    // R12: other control codes
    step(8'hBC, 1, 0, "R12 other control");
    step(8'h1C, 1, 0, "R12 other control");
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      int r;
      logic [7:0] o; logic c;
      r = int'($urandom % 100);
      o = 8'($urandom % 4); c = 0;
      if (r < 8) begin o = 8'hFC; c = 1; end
      else if (r < 14) begin o = 8'h7C; c = 1; end
      else if (r < 16) begin o = 8'hBC; c = 1; end
      step(o, c, ($urandom % 150) == 0, "R3 R4 R9 R10 R11 random");
    end
    summary();
  end
endmodule